// File: doc/BRIEF.md
# Arithmetic Status Flag Unit

This block performs an 8-bit or 16-bit addition or subtraction and derives the processor status flags from it. It has four operations: plain add, add with an incoming carry, plain subtract, and subtract with an incoming borrow. A width select chooses whether the low byte or the full word takes part. The sum or difference appears combinationally on the result port. A flag register captures the arithmetic flags whenever the update enable is high.

The same register holds three control bits that software writes directly: block-transfer direction, interrupt enable and single-step trap. Each has its own set and clear inputs, and the arithmetic path never touches them. The flag word is 16 bits wide, and positions that carry no flag always read zero.

Top module: `status_flag_unit`

## Requirements
- R1: The result is a+b (op 00), a+b+cin (op 01), a-b (op 10) or a-b-cin (op 11), all modulo the selected width. With `byte_mode_i` high only the low bytes are used and result bits 15:8 are 0. The carry input has no effect in ops 00 and 10.
- R2: Flag bit 0 (carry) is the carry out of the selected width for ops 00/01. For ops 10/11 it is the borrow, set when the unsigned minuend is smaller than the subtrahend plus the borrow in.
- R3: Flag bit 11 (overflow) is 1 when the two's-complement result does not fit the selected width (8 or 16 bits).
- R4: Flag bit 7 (sign) equals the most significant bit of the selected-width result (bit 7 or bit 15). Flag bit 6 (zero) is 1 exactly when the selected-width result is 0.
- R5: Flag bit 4 (auxiliary) is the carry out of the low 4 bits for ops 00/01. For ops 10/11 it is the borrow out of the low 4 bits.
- R6: Flag bit 2 (parity) is 1 when result bits 7:0 contain an even number of ones.
- R7: The arithmetic flags (bits 0, 2, 4, 6, 7, 11) load on a rising clock edge only when `upd_i` is 1. Otherwise they hold their value.
- R8: Control bits are direction (bit 10), interrupt enable (bit 9) and trap (bit 8). Each is set by its set input and cleared by its clear input at a clock edge. Set wins when both are high. No other input changes them.
- R9: A synchronous active-low reset clears the whole flag word to 0. Bits 1, 3, 5 and 15:12 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| a_i | input | 16 | First operand (minuend for subtract) |
| b_i | input | 16 | Second operand (subtrahend for subtract) |
| op_i | input | 2 | 00 add, 01 add with carry, 10 subtract, 11 subtract with borrow |
| byte_mode_i | input | 1 | 1 selects 8-bit operation on the low bytes |
| carry_in_i | input | 1 | Incoming carry or borrow for ops 01/11 |
| upd_i | input | 1 | Load enable for the arithmetic flags |
| dir_set_i | input | 1 | Set the direction bit |
| dir_clr_i | input | 1 | Clear the direction bit |
| int_set_i | input | 1 | Set the interrupt enable bit |
| int_clr_i | input | 1 | Clear the interrupt enable bit |
| trap_set_i | input | 1 | Set the trap bit |
| trap_clr_i | input | 1 | Clear the trap bit |
| result_o | output | 16 | Sum or difference, zero-extended in byte mode |
| flags_o | output | 16 | Registered flag word |

## Verification
The operand table covers wrap to zero, signed overflow in both directions, and a carry or borrow that reaches bit 4 but not the top bit. It also covers each of these in byte mode with nonzero upper operand bytes. These cases separate the bit-7 and bit-15 tap points and separate carry from overflow. Ops 00 and 10 are also driven with the carry input high, which exposes a design that always folds the carry in. A vector with `upd_i` low and a set/clear sequence with simultaneous set and clear show the two halves of the register are independent, and that set has priority.

// File: rtl/sfu_pkg.sv
// Shared definitions for the status flag unit: operation codes and
// flag word bit positions. Assumes a 16-bit flag word.
package sfu_pkg;
    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_ADC = 2'b01,
        OP_SUB = 2'b10,
        OP_SBB = 2'b11
    } sfu_op_e;

    localparam int FLAG_W  = 16;
    localparam int FB_CY   = 0;
    localparam int FB_PAR  = 2;
    localparam int FB_AUX  = 4;
    localparam int FB_ZERO = 6;
    localparam int FB_SIGN = 7;
    localparam int FB_TRAP = 8;
    localparam int FB_INT  = 9;
    localparam int FB_DIR  = 10;
    localparam int FB_OVF  = 11;
    localparam int CTRL_N  = 3;

    localparam logic [FLAG_W-1:0] ARITH_MASK =
        FLAG_W'((1 << FB_CY) | (1 << FB_PAR) | (1 << FB_AUX) |
                (1 << FB_ZERO) | (1 << FB_SIGN) | (1 << FB_OVF));
    localparam logic [FLAG_W-1:0] CTRL_MASK =
        FLAG_W'((1 << FB_TRAP) | (1 << FB_INT) | (1 << FB_DIR));
endpackage

// File: rtl/sfu_adder.sv
// Shared adder for add and subtract at full or half width.
// Subtraction is a + ~b + 1 (or + 0 when a borrow comes in).
// Outputs are raw carries: the flag stage turns them into borrows.
// Assumes DATA_W is even and at least 8.
module sfu_adder #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              sub_i,
    input  logic              use_c_i,
    input  logic              carry_i,
    input  logic              narrow_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              cout_o,
    output logic              aux_c_o,
    output logic              ovf_o
);
    localparam int NW = DATA_W / 2;

    logic [DATA_W-1:0] b_eff;
    logic              c_eff;
    logic [DATA_W:0]   wide_sum;
    logic [NW:0]       nar_sum;
    logic              c_msb_w, c_msb_n;

    // Operand conditioning: invert the subtrahend and pick the carry into bit 0
    always_comb begin
        b_eff = sub_i ? ~b_i : b_i;
        c_eff = sub_i ? ~(use_c_i & carry_i) : (use_c_i & carry_i);
    end

    // Both widths are summed in parallel and the width select picks one
    always_comb begin
        wide_sum = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, c_eff};
        nar_sum  = {1'b0, a_i[NW-1:0]} + {1'b0, b_eff[NW-1:0]} + {{NW{1'b0}}, c_eff};
        c_msb_w  = a_i[DATA_W-1] ^ b_eff[DATA_W-1] ^ wide_sum[DATA_W-1];
        c_msb_n  = a_i[NW-1] ^ b_eff[NW-1] ^ nar_sum[NW-1];
    end

    // Output selection; the carry into bit 4 is the same for both widths
    always_comb begin
        aux_c_o = a_i[4] ^ b_eff[4] ^ wide_sum[4];
        if (narrow_i) begin
            sum_o  = {{(DATA_W-NW){1'b0}}, nar_sum[NW-1:0]};
            cout_o = nar_sum[NW];
            ovf_o  = c_msb_n ^ nar_sum[NW];
        end else begin
            sum_o  = wide_sum[DATA_W-1:0];
            cout_o = wide_sum[DATA_W];
            ovf_o  = c_msb_w ^ wide_sum[DATA_W];
        end
    end
endmodule

// File: rtl/sfu_flag_calc.sv
// Builds the arithmetic part of the flag word from the adder outputs.
// Turns carries into borrows on subtraction. Assumes sum_i is already
// zero-extended in narrow mode.
module sfu_flag_calc
    import sfu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] sum_i,
    input  logic              cout_i,
    input  logic              aux_c_i,
    input  logic              ovf_i,
    input  logic              sub_i,
    input  logic              narrow_i,
    output logic [FLAG_W-1:0] arith_o
);
    localparam int NW = DATA_W / 2;
    localparam int PW = 8;

    // Place each derived flag at its fixed bit; all others stay zero
    always_comb begin
        arith_o          = '0;
        arith_o[FB_CY]   = cout_i ^ sub_i;
        arith_o[FB_AUX]  = aux_c_i ^ sub_i;
        arith_o[FB_OVF]  = ovf_i;
        arith_o[FB_SIGN] = narrow_i ? sum_i[NW-1] : sum_i[DATA_W-1];
        arith_o[FB_ZERO] = (sum_i == '0);
        arith_o[FB_PAR]  = ~(^sum_i[PW-1:0]);
    end
endmodule

// File: rtl/sfu_flag_reg.sv
// Flag storage. The arithmetic bits load on the update enable. Each
// control bit has its own set/clear pair, and set has priority.
// Reset is synchronous and active low.
module sfu_flag_reg
    import sfu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_i,
    input  logic [FLAG_W-1:0] arith_i,
    input  logic [CTRL_N-1:0] set_i,
    input  logic [CTRL_N-1:0] clr_i,
    output logic [FLAG_W-1:0] flags_o
);
    logic [FLAG_W-1:0] arith_q;
    logic [CTRL_N-1:0] ctrl_q;

    // Arithmetic flag capture, gated by the update enable
    always_ff @(posedge clk) begin
        if (!rst_n)     arith_q <= '0;
        else if (upd_i) arith_q <= arith_i & ARITH_MASK;
    end

    // One set/clear cell per control bit
    for (genvar k = 0; k < CTRL_N; k++) begin : g_ctrl
        always_ff @(posedge clk) begin
            if (!rst_n)        ctrl_q[k] <= 1'b0;
            else if (set_i[k]) ctrl_q[k] <= 1'b1;
            else if (clr_i[k]) ctrl_q[k] <= 1'b0;
        end

        AST_CTRL_SET: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[k] |=> ctrl_q[k]); // R8
        AST_CTRL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[k] && !set_i[k]) |=> !ctrl_q[k]); // R8
        AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_i[k] && !clr_i[k]) |=> $stable(ctrl_q[k])); // R8
    end

    // Merge the two halves into the flag word
    always_comb begin
        flags_o = arith_q;
        flags_o[FB_TRAP + CTRL_N - 1 : FB_TRAP] = ctrl_q;
    end

    AST_ARITH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_i |=> $stable(arith_q)); // R7
endmodule

// File: rtl/status_flag_unit.sv
// Top of the status flag unit. Contains the adder, the flag derivation
// and the flag register. The result is combinational and the flags are
// registered. Op codes and bit positions come from sfu_pkg.
module status_flag_unit
    import sfu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [1:0]        op_i,
    input  logic              byte_mode_i,
    input  logic              carry_in_i,
    input  logic              upd_i,
    input  logic              dir_set_i,
    input  logic              dir_clr_i,
    input  logic              int_set_i,
    input  logic              int_clr_i,
    input  logic              trap_set_i,
    input  logic              trap_clr_i,
    output logic [DATA_W-1:0] result_o,
    output logic [FLAG_W-1:0] flags_o
);
    localparam int NW = DATA_W / 2;

    logic              sub_w, use_c_w, cout_w, aux_w, ovf_w;
    logic [DATA_W-1:0] sum_w;
    logic [FLAG_W-1:0] arith_w;
    logic [CTRL_N-1:0] set_w, clr_w;

    // Op decode: the high bit selects subtract, the low bit folds in the carry
    always_comb begin
        sub_w   = op_i[1];
        use_c_w = op_i[0];
        set_w   = {dir_set_i, int_set_i, trap_set_i};
        clr_w   = {dir_clr_i, int_clr_i, trap_clr_i};
    end

    sfu_adder #(.DATA_W(DATA_W)) u_add (
        .a_i(a_i), .b_i(b_i), .sub_i(sub_w), .use_c_i(use_c_w),
        .carry_i(carry_in_i), .narrow_i(byte_mode_i),
        .sum_o(sum_w), .cout_o(cout_w), .aux_c_o(aux_w), .ovf_o(ovf_w)
    );

    sfu_flag_calc #(.DATA_W(DATA_W)) u_calc (
        .sum_i(sum_w), .cout_i(cout_w), .aux_c_i(aux_w), .ovf_i(ovf_w),
        .sub_i(sub_w), .narrow_i(byte_mode_i), .arith_o(arith_w)
    );

    sfu_flag_reg u_reg (
        .clk(clk), .rst_n(rst_n), .upd_i(upd_i), .arith_i(arith_w),
        .set_i(set_w), .clr_i(clr_w), .flags_o(flags_o)
    );

    assign result_o = sum_w;

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o & ~(ARITH_MASK | CTRL_MASK)) == '0); // R9
    AST_BYTE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        byte_mode_i |-> result_o[DATA_W-1:NW] == '0); // R1
    AST_UPD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && result_o == '0) |=> flags_o[FB_ZERO]); // R4
endmodule

// File: tb/status_flag_unit_tb.sv
module status_flag_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] a = '0, b = '0;
    logic [1:0]  op = '0;
    logic        bm = 1'b0, cin = 1'b0, upd = 1'b0;
    logic        ds = 0, dc = 0, is_ = 0, ic = 0, ts = 0, tc = 0;
    logic [15:0] result, flags;
    int          errors = 0, checks = 0;

    always #10 clk = ~clk;

    status_flag_unit u_dut (
        .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .op_i(op),
        .byte_mode_i(bm), .carry_in_i(cin), .upd_i(upd),
        .dir_set_i(ds), .dir_clr_i(dc), .int_set_i(is_), .int_clr_i(ic),
        .trap_set_i(ts), .trap_clr_i(tc), .result_o(result), .flags_o(flags)
    );

    // vector: {a, b, op, byte_mode, carry_in}
    localparam int NV = 16;
    localparam logic [35:0] VEC [NV] = '{
        {16'h0001, 16'h0001, 2'b00, 1'b0, 1'b0},
        {16'hFFFF, 16'h0001, 2'b00, 1'b0, 1'b0},
        {16'h7FFF, 16'h0001, 2'b00, 1'b0, 1'b0},
        {16'h12FF, 16'h3401, 2'b00, 1'b1, 1'b0},
        {16'hAA70, 16'h5510, 2'b00, 1'b1, 1'b0},
        {16'h1234, 16'h0000, 2'b01, 1'b0, 1'b1},
        {16'h1234, 16'h0000, 2'b00, 1'b0, 1'b1},
        {16'h0000, 16'h0001, 2'b10, 1'b0, 1'b0},
        {16'h8000, 16'h0001, 2'b10, 1'b0, 1'b0},
        {16'h0010, 16'h0000, 2'b11, 1'b0, 1'b1},
        {16'hFF05, 16'h0105, 2'b11, 1'b1, 1'b0},
        {16'h0080, 16'hFF01, 2'b10, 1'b1, 1'b0},
        {16'h3300, 16'h00FF, 2'b11, 1'b1, 1'b1},
        {16'h000F, 16'h0000, 2'b01, 1'b1, 1'b1},
        {16'h0005, 16'h0003, 2'b10, 1'b0, 1'b1},
        {16'h8000, 16'h8000, 2'b00, 1'b0, 1'b0}
    };

    localparam logic [15:0] ARITH_BITS = 16'h08D5;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model written from the requirements using integer arithmetic
    function automatic void model(input logic [15:0] ia, ib, input logic [1:0] iop,
                                  input logic ibm, icin,
                                  output logic [15:0] res, output logic [15:0] fl);
        int w    = ibm ? 8 : 16;
        int mask = (1 << w) - 1;
        int half = 1 << (w - 1);
        int aa   = int'(ia) & mask;
        int bb   = int'(ib) & mask;
        int c    = iop[0] ? int'(icin) : 0;
        int sa   = (aa >= half) ? aa - 2 * half : aa;
        int sb   = (bb >= half) ? bb - 2 * half : bb;
        int raw, sr;
        fl = '0;
        if (!iop[1]) begin
            raw   = aa + bb + c;
            sr    = sa + sb + c;
            fl[0] = raw > mask;
            fl[4] = ((aa & 15) + (bb & 15) + c) > 15;
        end else begin
            raw   = aa - bb - c;
            sr    = sa - sb - c;
            fl[0] = aa < bb + c;
            fl[4] = (aa & 15) < (bb & 15) + c;
        end
        res    = 16'(raw & mask);
        fl[11] = (sr >= half) || (sr < -half);
        fl[7]  = ((int'(res) >> (w - 1)) & 1) == 1;
        fl[6]  = (res == 16'h0000);
        fl[2]  = ($countones(res[7:0]) % 2) == 0;
    endfunction

    initial begin
        #(20 * 100000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] er, ef, held;
        repeat (3) @(negedge clk);
        chk("R9 reset clears flag word", flags, 16'h0000);
        rst_n = 1'b1;

        // Table walk: result before the edge, flags after it
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {a, b, op, bm, cin} = VEC[i];
            upd = 1'b1;
            model(a, b, op, bm, cin, er, ef);
            #2;
            chk($sformatf("R1 result vec%0d", i), result, er);
            @(negedge clk);
            chk($sformatf("R2 carry vec%0d", i), {15'b0, flags[0]}, {15'b0, ef[0]});
            chk($sformatf("R3 overflow vec%0d", i), {15'b0, flags[11]}, {15'b0, ef[11]});
            chk($sformatf("R4 sign/zero vec%0d", i), {14'b0, flags[7:6]}, {14'b0, ef[7:6]});
            chk($sformatf("R5 aux vec%0d", i), {15'b0, flags[4]}, {15'b0, ef[4]});
            chk($sformatf("R6 parity vec%0d", i), {15'b0, flags[2]}, {15'b0, ef[2]});
            chk($sformatf("R9 unused bits vec%0d", i), flags & 16'hF02A, 16'h0000);
        end

        // R7: with the update enable low, a new operation leaves flags alone
        held = flags;
        upd = 1'b0; a = 16'hFFFF; b = 16'h0001; op = 2'b00; bm = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R7 flags hold without update", flags, held);

        // R8: control bits set and clear, arithmetic bits untouched
        ds = 1; is_ = 1; ts = 1;
        @(negedge clk);
        ds = 0; is_ = 0; ts = 0;
        chk("R8 control bits set", flags & 16'h0700, 16'h0700);
        chk("R8 set leaves arith bits", flags & ARITH_BITS, held & ARITH_BITS);
        dc = 1;
        @(negedge clk);
        dc = 0;
        chk("R8 direction clear", flags & 16'h0700, 16'h0300);
        ts = 1; tc = 1;
        @(negedge clk);
        ts = 0; tc = 0;
        chk("R8 set wins over clear", flags & 16'h0700, 16'h0300);
        ic = 1;
        @(negedge clk);
        ic = 0;
        chk("R8 interrupt clear", flags & 16'h0700, 16'h0100);

        // R7/R8: an update changes arithmetic bits but not control bits
        upd = 1'b1; a = 16'h0000; b = 16'h0000; op = 2'b10; bm = 1'b0;
        @(negedge clk);
        upd = 1'b0;
        chk("R8 update leaves control bits", flags & 16'h0700, 16'h0100);
        chk("R7 update loads arith flags", flags & ARITH_BITS, 16'h0044);

        // R9: mid-run reset clears control and arithmetic bits
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 reset mid-run", flags, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule